// File: doc/BRIEF.md
# Ramp-Search Threshold Capture

This block measures an analog level by searching upward from zero. When a start strobe arrives it clears a code counter that feeds an external DAC. The counter then climbs by one step on every step tick. An external comparator reports when the DAC output is at or above the sensed level. At that point the current code is latched as the held value, and it stays there as a plain register that never decays. The time a capture takes grows with the level found: a low level finishes almost at once, and a level above full scale takes the longest.

A supply-good input guards the stored result. While it is high the held code does not change unless a later capture completes. When it drops, the held code, the run state and the completion pulse are cleared. The step rate is set by a clock divider parameter. An optional synchronizer can be placed on the comparator input.

Top module: `cap_sample_hold`

## Requirements
- R1: While reset is asserted, `dac_code_o`, `held_code_o`, `done_o` and `busy_o` are all zero.
- R2: A high `start_i` at a clock edge where `busy_o` is low and `por_ok_i` is high starts a capture. After that edge `busy_o` is 1 and `dac_code_o` is 0.
- R3: While busy and the comparator is low, `dac_code_o` rises by exactly one every `STEP_DIV` cycles. It never changes by any other amount. Capturing level L takes L*STEP_DIV+1 cycles from the start edge to the edge that raises done.
- R4: At an edge where the block is busy and `cmp_hi_i` is high, `held_code_o` takes the current `dac_code_o`. `done_o` rises and `busy_o` falls. If a step tick falls in the same cycle, the trip wins and the code is not incremented.
- R5: If a step tick comes while the code is all ones (63 at default width) and the comparator is low, the code stays at all ones. `held_code_o` becomes all ones, `done_o` rises and `busy_o` falls. A level above full scale therefore takes (2^CODE_W)*STEP_DIV cycles.
- R6: `done_o` is high for exactly one cycle per completed capture.
- R7: While `por_ok_i` stays high, `held_code_o` changes only at an edge that raises `done_o`. It keeps its old value throughout a new capture.
- R8: At an edge where `por_ok_i` is low, `held_code_o`, `dac_code_o`, `done_o` and `busy_o` are cleared to zero. `start_i` has no effect while `por_ok_i` is low.
- R9: `start_i` while busy is ignored. The running capture is not restarted.
- R10: `cmp_hi_i` is ignored while idle. It causes no done pulse and does not change the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a capture |
| cmp_hi_i | input | 1 | Comparator result, high when DAC output >= sensed level |
| por_ok_i | input | 1 | Supply-good flag; low clears the stored result |
| dac_code_o | output | CODE_W | Code driving the external DAC |
| held_code_o | output | CODE_W | Captured code |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while a capture runs |

## Verification
The comparator trip and the step tick can both happen in one cycle. This is provoked by dropping the bench's sensed level to zero at four successive cycle offsets inside a running capture, so that one offset lands on the divider's last count. A reference model, in which the trip always wins, judges every cycle and checks that the code latched is the one before any increment. At full scale, the trip and saturation meet in the same way: a level of exactly 63 must end by a trip one cycle after reaching 63, while a level of 64 must end by saturation on the next tick. The measured conversion times tell the two cases apart.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [0:0] {
      CAP_IDLE = 1'b0,
      CAP_RAMP = 1'b1
   } cap_state_e;

   typedef struct packed {
      logic clr;   // force counter to zero
      logic inc;   // step counter by one
      logic cap;   // latch counter into held register
   } cap_cmd_t;

endpackage

// File: rtl/cap_step_timer.sv
module cap_step_timer #(
   parameter int unsigned STEP_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   output logic tick_o
);

   if (STEP_DIV < 1) begin : g_chk_div
      $error("cap_step_timer: STEP_DIV must be at least 1");
   end

   if (STEP_DIV == 1) begin : g_every_cycle
      assign tick_o = run_i;
   end else begin : g_divider
      localparam int unsigned DIV_W = $clog2(STEP_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);

      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            div_q <= '0;
         end else if (clear_i) begin
            div_q <= '0;
         end else if (run_i) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
         end
      end

      assign tick_o = run_i && (div_q == LAST);

      AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         div_q <= LAST);  // R3
   end

endmodule

// File: rtl/cap_cmp_sync.sv
module cap_cmp_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cmp_i,
   output logic cmp_o
);

   if (STAGES == 0) begin : g_direct
      assign cmp_o = cmp_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sh_q <= '0;
         end else begin
            sh_q <= {sh_q[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, cmp_i};
         end
      end

      assign cmp_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/cap_ramp_counter.sv
module cap_ramp_counter #(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [CODE_W-1:0] code_o,
   output logic              at_max_o
);

   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
      end else if (clr_i) begin
         code_q <= '0;
      end else if (inc_i && (code_q != FULL)) begin
         code_q <= code_q + 1'b1;
      end
   end

   assign code_o   = code_q;
   assign at_max_o = (code_q == FULL);

   AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1));  // R3

   AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (at_max_o && !clr_i) |=> at_max_o);  // R5

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     por_ok_i,
   input  logic     start_i,
   input  logic     trip_i,
   input  logic     tick_i,
   input  logic     at_max_i,
   output cap_cmd_t cmd_o,
   output logic     busy_o,
   output logic     done_o
);

   cap_state_e state_q;
   cap_state_e state_d;
   logic       done_q;
   logic       accept;
   logic       finish;

   always_comb begin
      accept = (state_q == CAP_IDLE) && start_i && por_ok_i;
      finish = (state_q == CAP_RAMP) && por_ok_i && (trip_i || (tick_i && at_max_i));

      cmd_o.clr = !por_ok_i || accept;
      cmd_o.inc = (state_q == CAP_RAMP) && por_ok_i && !trip_i && tick_i && !at_max_i;
      cmd_o.cap = finish;

      state_d = state_q;
      if (!por_ok_i) begin
         state_d = CAP_IDLE;
      end else if (accept) begin
         state_d = CAP_RAMP;
      end else if (finish) begin
         state_d = CAP_IDLE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CAP_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
      end
   end

   assign busy_o = (state_q == CAP_RAMP);
   assign done_o = done_q;

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);  // R6

   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);  // R4

   AST_POR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !por_ok_i |=> (!busy_o && !done_o));  // R8

   AST_IDLE_TRIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && trip_i) |=> !done_o);  // R10

endmodule

// File: rtl/cap_sample_hold.sv
module cap_sample_hold #(
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned STEP_DIV = 4,
   parameter int unsigned CMP_SYNC = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              cmp_hi_i,
   input  logic              por_ok_i,
   output logic [CODE_W-1:0] dac_code_o,
   output logic [CODE_W-1:0] held_code_o,
   output logic              done_o,
   output logic              busy_o
);
   import cap_pkg::*;

   if (CODE_W < 2 || CODE_W > 16) begin : g_chk_width
      $error("cap_sample_hold: CODE_W must lie in 2..16");
   end
   if (CMP_SYNC > 4) begin : g_chk_sync
      $error("cap_sample_hold: CMP_SYNC must not exceed 4");
   end

   cap_cmd_t          cmd;
   logic              trip;
   logic              tick;
   logic              at_max;
   logic              busy;
   logic [CODE_W-1:0] code;
   logic [CODE_W-1:0] held_q;

   cap_cmp_sync #(.STAGES(CMP_SYNC)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmp_i  (cmp_hi_i),
      .cmp_o  (trip)
   );

   cap_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (cmd.clr),
      .run_i   (busy),
      .tick_o  (tick)
   );

   cap_ramp_counter #(.CODE_W(CODE_W)) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (cmd.clr),
      .inc_i    (cmd.inc),
      .code_o   (code),
      .at_max_o (at_max)
   );

   cap_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .por_ok_i (por_ok_i),
      .start_i  (start_i),
      .trip_i   (trip),
      .tick_i   (tick),
      .at_max_i (at_max),
      .cmd_o    (cmd),
      .busy_o   (busy),
      .done_o   (done_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= '0;
      end else if (!por_ok_i) begin
         held_q <= '0;
      end else if (cmd.cap) begin
         held_q <= code;
      end
   end

   assign dac_code_o  = code;
   assign held_code_o = held_q;
   assign busy_o      = busy;

   AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_ok_i |=> ($stable(held_code_o) || done_o));  // R7

   AST_POR_CLEARS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !por_ok_i |=> (held_code_o == '0 && dac_code_o == '0));  // R8

   AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && por_ok_i && dac_code_o != '0) |=> (dac_code_o != '0));  // R9

   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i && por_ok_i) |=> (busy_o && dac_code_o == '0));  // R2

endmodule

// File: tb/test_cap_sample_hold.sv
`timescale 1ns/1ps
module test_cap_sample_hold;

   localparam int CW   = 6;
   localparam int DIV  = 4;
   localparam int MAXV = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          por_ok = 1'b1;
   int            level = 100;
   logic          cmp_hi;
   logic [CW-1:0] dac_code;
   logic [CW-1:0] held_code;
   logic          done;
   logic          busy;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign cmp_hi = (int'(dac_code) >= level);

   cap_sample_hold #(.CODE_W(CW), .STEP_DIV(DIV), .CMP_SYNC(0)) i_cap_sample_hold (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .cmp_hi_i    (cmp_hi),
      .por_ok_i    (por_ok),
      .dac_code_o  (dac_code),
      .held_code_o (held_code),
      .done_o      (done),
      .busy_o      (busy)
   );

   // behavioural reference
   int m_cnt = 0, m_held = 0, m_div = 0, m_busy = 0, m_done = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_held = 0; m_div = 0; m_busy = 0; m_done = 0;
      end else if (!por_ok) begin
         m_cnt = 0; m_held = 0; m_div = 0; m_busy = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_busy == 0) begin
            if (start) begin
               m_busy = 1; m_cnt = 0; m_div = 0;
            end
         end else if (m_cnt >= level) begin
            m_held = m_cnt; m_done = 1; m_busy = 0;
         end else if (m_div == DIV - 1) begin
            m_div = 0;
            if (m_cnt == MAXV) begin
               m_held = MAXV; m_done = 1; m_busy = 0;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end else begin
            m_div = m_div + 1;
         end
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3", "dac code", int'(dac_code), m_cnt);
         chk("R7", "held code", int'(held_code), m_held);
         chk("R6", "done", int'(done), m_done);
         chk("R2", "busy", int'(busy), m_busy);
      end
   end

   task automatic conv(input int lvl, output int n);
      level = lvl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         n++;
         if (done) break;
      end
   endtask

   function automatic int exp_time(input int lvl);
      if (lvl > MAXV) return (MAXV + 1) * DIV;
      return lvl * DIV + 1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "dac in reset", int'(dac_code), 0);
      chk("R1", "held in reset", int'(held_code), 0);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "busy in reset", int'(busy), 0);
      rst_n = 1'b1;

      // R10 comparator high while idle
      level = 0;
      repeat (6) @(negedge clk);
      chk("R10", "done idle trip", int'(done), 0);
      chk("R10", "held idle trip", int'(held_code), 0);

      // R4 basic captures, R3 timing
      conv(0, n);
      chk("R4", "held level 0", int'(held_code), 0);
      chk("R3", "time level 0", n, exp_time(0));
      conv(5, n);
      chk("R4", "held level 5", int'(held_code), 5);
      chk("R3", "time level 5", n, exp_time(5));
      conv(20, n);
      chk("R4", "held level 20", int'(held_code), 20);
      chk("R3", "time level 20", n, exp_time(20));
      conv(63, n);
      chk("R4", "held level 63", int'(held_code), 63);
      chk("R4", "time level 63", n, exp_time(63));

      // R5 saturation
      conv(64, n);
      chk("R5", "held saturated", int'(held_code), MAXV);
      chk("R5", "dac saturated", int'(dac_code), MAXV);
      chk("R5", "time saturated", n, exp_time(64));

      // R9 start while busy ignored
      level = 30;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 21;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         n++;
         if (done) break;
      end
      chk("R9", "held after restart try", int'(held_code), 30);
      chk("R9", "time after restart try", n, exp_time(30));

      // R7 held stays during a new capture
      level = 50;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      chk("R7", "held during capture", int'(held_code), 30);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (done) break;
      end
      chk("R7", "held new value", int'(held_code), 50);

      // R4 trip against step tick at every divider phase
      for (int off = 0; off < 4; off++) begin
         level = 200;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (10 + off) @(negedge clk);
         level = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) break;
         end
         chk("R4", "held at collision", int'(held_code), m_held);
         chk("R4", "held collision value", int'(held_code), (10 + off) / DIV);
      end

      // R8 supply loss
      level = 40;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      por_ok = 1'b0;
      @(negedge clk);
      chk("R8", "busy after por loss", int'(busy), 0);
      chk("R8", "held after por loss", int'(held_code), 0);
      chk("R8", "dac after por loss", int'(dac_code), 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R8", "start while por low", int'(busy), 0);
      por_ok = 1'b1;
      @(negedge clk);
      chk("R8", "held after por return", int'(held_code), 0);
      conv(7, n);
      chk("R4", "held after recovery", int'(held_code), 7);

      // R7 long idle with moving level
      for (int i = 0; i < 50; i++) begin
         level = i % 9;
         @(negedge clk);
      end
      chk("R7", "held after idle", int'(held_code), 7);
      chk("R10", "busy after idle", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule